// File: doc/BRIEF.md
# Delayed Store Write Buffer for a Direct-Mapped Data Cache

This block sits between a pipeline's memory stage and a small direct-mapped data cache whose data array has a single port. It lets a store finish in one memory-stage cycle. The store's tag lookup happens in its own cycle. On a hit, its address, data and byte enables are parked in a one-entry buffer. The parked store is written into the data array later, during the cycle in which the next store does its tag lookup. That cycle leaves the data port free, because a store only needs the tag array.

Because the array can hold stale data for the most recent store, a load whose address equals the buffered address takes the buffered bytes. The bytes the pending store did not enable come from the array. A store that misses raises a miss, is not buffered, and leaves line recovery to the external refill port. A refill or a flush request first drains any pending store into the array, so no update is lost. While a refill or flush occupies the array, the CPU port is held off.

Addresses are word addresses. The low `IDX_W` bits select the cache line (one word per line) and the remaining bits form the tag.

Top module: `stwb_cache_front`

## Requirements
- R1: After reset every line is invalid and the buffer is empty: any load reports a miss, and `req_ready` and `refill_ready` are both high.
- R2: A store that hits completes in its request cycle, with `rsp_hit` high and `rsp_miss` low, and its address, data and byte enables enter the buffer at the following edge.
- R3: A buffered store is written into the data array in the cycle of the next accepted store's tag lookup, whether that store hits or misses. A later load to the older address, once it is no longer buffered, returns the merged data from the array.
- R4: A load whose address equals the buffered store's address returns the buffered data as a hit, including a load in the cycle right after the store.
- R5: Byte enable bit i covers data bits [8i+7:8i]. On a bypass, bytes enabled in the buffered store come from the buffer and the other bytes come from the array.
- R6: A store whose tag does not match, or whose line is invalid, raises `rsp_miss`, is not buffered, and changes no cached data. The buffer is left empty afterwards, so `refill_ready` is high in the next cycle.
- R7: A refill presented while a store is buffered sees `refill_ready` low for exactly one cycle while the store drains, and is then accepted. The drained store's data is kept unless the refill replaces that same line.
- R8: A flush request drains a pending store and empties the buffer in one cycle. A refill presented right after a flush is accepted at once.
- R9: While `refill_valid` or `flush_req` is high, `req_ready` is low, the CPU request is ignored, and neither `rsp_hit` nor `rsp_miss` is raised.
- R10: An accepted refill installs its tag and data word in the line chosen by its address. Loads to that address then hit and return the data, and loads with another tag to that line miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | CPU request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Store data |
| req_be | input | DATA_W/8 | Store byte enables |
| req_ready | output | 1 | CPU request accepted this cycle |
| rsp_hit | output | 1 | Accepted request hit |
| rsp_miss | output | 1 | Accepted request missed |
| rsp_rdata | output | DATA_W | Load data, valid with a load hit |
| refill_valid | input | 1 | Refill word present |
| refill_addr | input | ADDR_W | Word address being installed |
| refill_data | input | DATA_W | Word being installed |
| refill_ready | output | 1 | Refill is taken this cycle when `refill_valid` is high |
| flush_req | input | 1 | Drain the pending store |

## Verification
The decisive overlap is a new store's tag lookup landing in the same cycle as the write-back of the previously buffered store. A related overlap is a load arriving one cycle after a store to the same address, while that data exists only in the buffer. Back-to-back stores to different and to equal addresses, with full and partial byte enables, provoke both. The loads that follow are compared with a reference line model that the bench updates from the requirements alone. Refill and flush requests arriving over a pending store exercise the drain-first ordering. A constrained random mix of loads, stores, refills and flushes then hunts for orderings the directed cases miss.

// File: rtl/stwb_pkg.sv
// Shared types for the delayed store write buffer.
package stwb_pkg;
    // Source of the single data-array write port in a given cycle.
    typedef enum logic [1:0] {
        WR_NONE   = 2'd0,
        WR_DRAIN  = 2'd1,
        WR_REFILL = 2'd2
    } wr_src_e;
endpackage

// File: rtl/stwb_tag_array.sv
// Tag store with one valid bit per line for a direct-mapped cache.
// Assumes one combinational lookup and at most one install per cycle.
module stwb_tag_array #(
    parameter int IDX_W = 3,
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0] tags  [LINES];
    logic [LINES-1:0] valid;

    // Lookup: line valid and stored tag equal to the request tag.
    always_comb rd_hit = valid[rd_idx] && (tags[rd_idx] == rd_tag);

    // Install a tag on refill; all lines start invalid after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
        end else if (wr_en) begin
            valid[wr_idx] <= 1'b1;
        end
    end

    // Tag contents need no reset; valid bits guard them.
    always_ff @(posedge clk) begin
        if (wr_en) tags[wr_idx] <= wr_tag;
    end
endmodule

// File: rtl/stwb_data_array.sv
// Single-ported data array, one word per line, with byte-enabled writes.
// Assumes the caller never issues a read and a write in the same cycle
// for the same purpose; the read is combinational.
module stwb_data_array #(
    parameter int IDX_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [DATA_W/8-1:0] wr_be
);
    localparam int LINES = 1 << IDX_W;
    localparam int NB    = DATA_W / 8;

    logic [DATA_W-1:0] mem [LINES];

    // Combinational read of the addressed word.
    always_comb rd_data = mem[rd_idx];

    // Byte-lane write of the selected word.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < NB; b++) begin
                if (wr_be[b]) mem[wr_idx][8*b +: 8] <= wr_data[8*b +: 8];
            end
        end
    end
endmodule

// File: rtl/stwb_store_buf.sv
// One-entry pending-store buffer with byte-lane bypass merge.
// Assumes load_en and clear come from the same control cycle; load wins.
module stwb_store_buf #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_en,
    input  logic                clear,
    input  logic [ADDR_W-1:0]   in_addr,
    input  logic [DATA_W-1:0]   in_data,
    input  logic [DATA_W/8-1:0] in_be,
    output logic                valid,
    output logic [ADDR_W-1:0]   addr,
    output logic [DATA_W-1:0]   data,
    output logic [DATA_W/8-1:0] be,
    input  logic [ADDR_W-1:0]   look_addr,
    input  logic [DATA_W-1:0]   base_data,
    output logic [DATA_W-1:0]   merged
);
    localparam int NB = DATA_W / 8;

    logic match;

    // Entry valid bit: set by a buffered store, dropped on drain.
    always_ff @(posedge clk) begin
        if (!rst_n)       valid <= 1'b0;
        else if (load_en) valid <= 1'b1;
        else if (clear)   valid <= 1'b0;
    end

    // Entry payload captured with each buffered store.
    always_ff @(posedge clk) begin
        if (load_en) begin
            addr <= in_addr;
            data <= in_data;
            be   <= in_be;
        end
    end

    // Address comparison for load bypass.
    always_comb match = valid && (addr == look_addr);

    // Per-lane merge: buffered byte over array byte when enabled.
    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign merged[8*b +: 8] = (match && be[b]) ? data[8*b +: 8]
                                                   : base_data[8*b +: 8];
    end
endmodule

// File: rtl/stwb_cache_front.sv
// Memory-stage front end of a direct-mapped cache with a delayed store
// buffer. Stores do a tag lookup only; the previous buffered store uses
// the free data port in that cycle. Assumes refill and flush are never
// requested together and that the CPU holds a request until req_ready.
module stwb_cache_front
    import stwb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_store,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    output logic                req_ready,
    output logic                rsp_hit,
    output logic                rsp_miss,
    output logic [DATA_W-1:0]   rsp_rdata,
    input  logic                refill_valid,
    input  logic [ADDR_W-1:0]   refill_addr,
    input  logic [DATA_W-1:0]   refill_data,
    output logic                refill_ready,
    input  logic                flush_req
);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int NB    = DATA_W / 8;

    logic              acc, st_acc, tag_hit, drain, refill_fire, buf_load;
    logic              buf_valid;
    logic [ADDR_W-1:0] buf_addr;
    logic [DATA_W-1:0] buf_data, arr_rdata;
    logic [NB-1:0]     buf_be;
    wr_src_e           wr_src;
    logic              arr_wr_en;
    logic [IDX_W-1:0]  arr_wr_idx;
    logic [DATA_W-1:0] arr_wr_data;
    logic [NB-1:0]     arr_wr_be;

    // CPU port is held off whenever refill or flush owns the arrays.
    always_comb req_ready = !(refill_valid || flush_req);

    // Accepted request qualifiers.
    always_comb begin
        acc    = req_valid && req_ready;
        st_acc = acc && req_store;
    end

    // Response flags for the accepted request.
    always_comb begin
        rsp_hit  = acc && tag_hit;
        rsp_miss = acc && !tag_hit;
    end

    // Drain the pending store on any store, flush or refill cycle.
    always_comb drain = buf_valid && (st_acc || flush_req || refill_valid);

    // Refill enters only once the buffer is empty.
    always_comb begin
        refill_ready = !buf_valid;
        refill_fire  = refill_valid && refill_ready;
        buf_load     = st_acc && tag_hit;
    end

    // Choose the single data-port writer for this cycle.
    always_comb begin
        if (refill_fire) wr_src = WR_REFILL;
        else if (drain)  wr_src = WR_DRAIN;
        else             wr_src = WR_NONE;
    end

    // Data-port write payload according to the chosen writer.
    always_comb begin
        arr_wr_en   = (wr_src != WR_NONE);
        arr_wr_idx  = buf_addr[IDX_W-1:0];
        arr_wr_data = buf_data;
        arr_wr_be   = buf_be;
        if (wr_src == WR_REFILL) begin
            arr_wr_idx  = refill_addr[IDX_W-1:0];
            arr_wr_data = refill_data;
            arr_wr_be   = '1;
        end
    end

    stwb_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (req_addr[IDX_W-1:0]),
        .rd_tag (req_addr[ADDR_W-1:IDX_W]),
        .rd_hit (tag_hit),
        .wr_en  (refill_fire),
        .wr_idx (refill_addr[IDX_W-1:0]),
        .wr_tag (refill_addr[ADDR_W-1:IDX_W])
    );

    stwb_data_array #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rd_idx  (req_addr[IDX_W-1:0]),
        .rd_data (arr_rdata),
        .wr_en   (arr_wr_en),
        .wr_idx  (arr_wr_idx),
        .wr_data (arr_wr_data),
        .wr_be   (arr_wr_be)
    );

    stwb_store_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (buf_load),
        .clear     (drain),
        .in_addr   (req_addr),
        .in_data   (req_wdata),
        .in_be     (req_be),
        .valid     (buf_valid),
        .addr      (buf_addr),
        .data      (buf_data),
        .be        (buf_be),
        .look_addr (req_addr),
        .base_data (arr_rdata),
        .merged    (rsp_rdata)
    );
endmodule

// File: rtl/stwb_checker.sv
// Protocol and ordering checks for stwb_cache_front, bound to every
// instance. Observes ports plus the buffer valid bit.
module stwb_checker #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_store,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [DATA_W-1:0]   req_wdata,
    input logic [DATA_W/8-1:0] req_be,
    input logic                req_ready,
    input logic                rsp_hit,
    input logic                rsp_miss,
    input logic [DATA_W-1:0]   rsp_rdata,
    input logic                refill_valid,
    input logic                refill_ready,
    input logic                flush_req,
    input logic                buf_valid
);
    logic              prev_full_hit;
    logic [ADDR_W-1:0] prev_addr;
    logic [DATA_W-1:0] prev_data;

    // Remember the last cycle's full-word store hit for the bypass check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_full_hit <= 1'b0;
            prev_addr     <= '0;
            prev_data     <= '0;
        end else begin
            prev_full_hit <= req_valid && req_ready && req_store && rsp_hit && (&req_be);
            prev_addr     <= req_addr;
            prev_data     <= req_wdata;
        end
    end

    // R2: a store hit is parked in the buffer.
    a_r2_store_hit_buffered: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_store && rsp_hit) |=> buf_valid);

    // R6: a store miss leaves the buffer empty.
    a_r6_store_miss_unbuffered: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_store && rsp_miss) |=> !buf_valid);

    // R4: load right after a full store to the same address sees its data.
    a_r4_next_cycle_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_full_hit && req_valid && req_ready && !req_store && req_addr == prev_addr)
        |-> (rsp_hit && rsp_rdata == prev_data));

    // R7: a held-off refill has drained the buffer by the next cycle.
    a_r7_refill_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_valid && !refill_ready) |=> !buf_valid);

    // R8: a flush empties the buffer.
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> !buf_valid);

    // R9: no CPU response while refill or flush owns the arrays.
    a_r9_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_valid || flush_req) |-> (!rsp_hit && !rsp_miss));
endmodule

bind stwb_cache_front stwb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_store    (req_store),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .req_be       (req_be),
    .req_ready    (req_ready),
    .rsp_hit      (rsp_hit),
    .rsp_miss     (rsp_miss),
    .rsp_rdata    (rsp_rdata),
    .refill_valid (refill_valid),
    .refill_ready (refill_ready),
    .flush_req    (flush_req),
    .buf_valid    (buf_valid)
);

// File: tb/stwb_cache_front_bench.sv
`timescale 1ns/1ps
module stwb_cache_front_bench;
    localparam int AW = 8;
    localparam int IW = 3;
    localparam int DW = 32;
    localparam int NB = DW / 8;
    localparam int LINES = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid, req_store, req_ready, rsp_hit, rsp_miss;
    logic [AW-1:0] req_addr, refill_addr;
    logic [DW-1:0] req_wdata, rsp_rdata, refill_data;
    logic [NB-1:0] req_be;
    logic          refill_valid, refill_ready, flush_req;

    int n_vec = 0;
    int n_err = 0;

    // Reference line model built from the requirements.
    logic              ref_vld [LINES];
    logic [AW-IW-1:0]  ref_tag [LINES];
    logic [DW-1:0]     ref_line[LINES];
    logic              ref_buf;

    always #10 clk = ~clk;

    stwb_cache_front #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) u_stwb_cache_front (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_store(req_store), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_rdata(rsp_rdata),
        .refill_valid(refill_valid), .refill_addr(refill_addr),
        .refill_data(refill_data), .refill_ready(refill_ready),
        .flush_req(flush_req)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_vec++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 0; req_store = 0; req_addr = '0; req_wdata = '0; req_be = '0;
        refill_valid = 0; refill_addr = '0; refill_data = '0; flush_req = 0;
    endtask

    function automatic logic ref_hit(input logic [AW-1:0] a);
        return ref_vld[a[IW-1:0]] && ref_tag[a[IW-1:0]] == a[AW-1:IW];
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw, input logic [NB-1:0] be);
        logic [DW-1:0] r = old;
        for (int b = 0; b < NB; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    task automatic do_load(input logic [AW-1:0] a, input string req);
        logic h;
        @(negedge clk); idle();
        req_valid = 1; req_addr = a;
        #5;
        h = ref_hit(a);
        chk(rsp_hit == h && rsp_miss == !h, req, {30'd0, rsp_hit, rsp_miss}, {30'd0, h, !h});
        if (h) chk(rsp_rdata == ref_line[a[IW-1:0]], req, rsp_rdata, ref_line[a[IW-1:0]]);
    endtask

    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NB-1:0] be, input string req);
        logic h;
        @(negedge clk); idle();
        req_valid = 1; req_store = 1; req_addr = a; req_wdata = d; req_be = be;
        #5;
        h = ref_hit(a);
        chk(req_ready && rsp_hit == h && rsp_miss == !h, req,
            {29'd0, req_ready, rsp_hit, rsp_miss}, {29'd0, 1'b1, h, !h});
        if (h) ref_line[a[IW-1:0]] = merge(ref_line[a[IW-1:0]], d, be);
        ref_buf = h;
    endtask

    task automatic do_refill(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
        @(negedge clk); idle();
        refill_valid = 1; refill_addr = a; refill_data = d;
        #5;
        chk(refill_ready == !ref_buf, req, {31'd0, refill_ready}, {31'd0, !ref_buf});
        chk(!req_ready && !rsp_hit && !rsp_miss, "R9", {29'd0, req_ready, rsp_hit, rsp_miss}, '0);
        if (ref_buf) begin
            ref_buf = 0;
            @(negedge clk);
            #5;
            chk(refill_ready == 1'b1, req, {31'd0, refill_ready}, 1);
        end
        ref_vld[a[IW-1:0]] = 1; ref_tag[a[IW-1:0]] = a[AW-1:IW]; ref_line[a[IW-1:0]] = d;
    endtask

    task automatic do_flush(input logic with_store, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk); idle();
        flush_req = 1;
        req_valid = with_store; req_store = 1; req_addr = a; req_wdata = d; req_be = '1;
        #5;
        chk(!req_ready && !rsp_hit && !rsp_miss, "R9", {29'd0, req_ready, rsp_hit, rsp_miss}, '0);
        ref_buf = 0;
    endtask

    task automatic t_reset();
        #5;
        chk(req_ready && refill_ready, "R1", {30'd0, req_ready, refill_ready}, 3);
        for (int i = 0; i < 4; i++) do_load(AW'(i * 9), "R1");
    endtask

    task automatic t_refill();
        for (int i = 0; i < LINES; i++) do_refill(AW'(i), 32'h1000_0000 + 32'(i * 32'h0101), "R10");
        for (int i = 0; i < LINES; i++) do_load(AW'(i), "R10");
        do_load(8'h2A, "R10");
    endtask

    task automatic t_bypass();
        do_store(8'h05, 32'hCAFE_0005, 4'hF, "R2");
        do_load(8'h05, "R4");
        do_store(8'h06, 32'hAABB_CCDD, 4'b0101, "R2");
        do_load(8'h06, "R5");
        do_load(8'h05, "R4");
    endtask

    task automatic t_drain();
        do_store(8'h01, 32'h1111_1111, 4'hF, "R2");
        do_store(8'h02, 32'h2222_2222, 4'b0011, "R3");
        do_load(8'h01, "R3");
        do_load(8'h02, "R5");
        do_store(8'h01, 32'h0000_00EE, 4'b0001, "R3");
        do_store(8'h01, 32'h00DD_0000, 4'b0100, "R3");
        do_load(8'h01, "R5");
        do_store(8'h03, 32'h3333_3333, 4'hF, "R3");
        do_load(8'h01, "R3");
    endtask

    task automatic t_miss();
        do_store(8'h04, 32'h4444_4444, 4'hF, "R2");
        do_store(8'h14, 32'hDEAD_BEEF, 4'hF, "R6");
        do_load(8'h04, "R6");
        do_load(8'h14, "R6");
        do_refill(8'h17, 32'h7777_0017, "R6");
        do_load(8'h17, "R10");
    endtask

    task automatic t_refill_pending();
        do_store(8'h02, 32'h5A5A_0002, 4'hF, "R2");
        do_refill(8'h1A, 32'hBEEF_001A, "R7");
        do_load(8'h1A, "R7");
        do_load(8'h02, "R7");
        do_store(8'h07, 32'h0707_0707, 4'b1100, "R2");
        do_refill(8'h10, 32'h1010_1010, "R7");
        do_load(8'h07, "R7");
        do_load(8'h10, "R10");
    endtask

    task automatic t_flush();
        do_store(8'h05, 32'hF1F1_F1F1, 4'hF, "R2");
        do_flush(1'b1, 8'h06, 32'h9999_9999);
        do_refill(8'h0B, 32'hB0B0_000B, "R8");
        do_load(8'h05, "R8");
        do_load(8'h06, "R9");
        do_flush(1'b0, '0, '0);
        do_refill(8'h0C, 32'hC0C0_000C, "R8");
    endtask

    task automatic t_random();
        for (int i = 0; i < 400; i++) begin
            int op = $urandom_range(0, 9);
            logic [AW-1:0] a = {3'd0, 2'($urandom_range(0, 1)), 3'($urandom)};
            logic [DW-1:0] d = $urandom;
            if (op < 4)       do_load(a, "R4");
            else if (op < 8)  do_store(a, d, NB'($urandom_range(1, 15)), "R3");
            else if (op == 8) do_refill(a, d, "R7");
            else              do_flush(1'b0, '0, '0);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        idle();
        for (int i = 0; i < LINES; i++) begin
            ref_vld[i] = 0; ref_tag[i] = '0; ref_line[i] = '0;
        end
        ref_buf = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        t_reset();
        t_refill();
        t_bypass();
        t_drain();
        t_miss();
        t_refill_pending();
        t_flush();
        t_random();
        @(negedge clk); idle();
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule